// File: doc/BRIEF.md
# Prescaled Interval Timer Channel

This block is a single timer channel for periodic interrupt generation. A 32-bit up-counter advances once per tick of a programmable power-of-two prescaler. The current count is compared with a software-written compare value. When the count reaches that value, a sticky match flag is raised. The interrupt request follows the flag, gated by an enable bit.

On a match the counter either wraps to zero and keeps running, which gives a periodic interrupt, or it stops at the compare value, which gives a one-shot delay. A second control bit decides whether stopping the counter also zeroes it. Software reaches the channel through a small word-addressed register bus. It writes control and compare, reads the live count, and clears the flag by writing zero to it.

The timer output pin is driven Low throughout, because only the interval mode is built. An option selects whether the interrupt output is combinational or registered.

Top module: `interval_timer_chan`

## Requirements
- R1: The prescaler code in CTRL[10:8] (code n) gives one counter tick every 2^(n+1) clock cycles, so code 0 divides by 2 and code 7 divides by 256.
- R2: The count rises by exactly one per tick while CTRL[0] (enable) is 1 and CTRL[5:4] (mode) is 00. With any other mode value, the counter behaves as if disabled.
- R3: While the counter is disabled, the count is forced to 0 if CTRL[1] (clear-on-stop) is 1, and otherwise keeps its value.
- R4: STAT[0] (match flag) becomes 1 on the same clock edge on which the count steps onto the compare value. It then stays 1 until software clears it.
- R5: The irq output is 1 only when the match flag is 1 and CTRL[3] (interrupt enable) is 1.
- R6: Writing a word with bit 0 equal to 0 to STAT clears the match flag. Writing bit 0 equal to 1 leaves the flag unchanged.
- R7: With CTRL[2] (wrap-on-match) equal to 1, the tick after a match returns the count to 0, and counting carries on toward the next match.
- R8: With CTRL[2] equal to 0, the count stops at the compare value and gives no further match events.
- R9: tmr_out is Low at all times.
- R10: The address map is 0 = CTRL, 1 = CMP, 2 = COUNT (read-only, live value) and 3 = STAT. CTRL and CMP read back the value that was written.
- R11: If a match event and a software clear of the flag fall on the same edge, the flag ends up set.
- R12: The prescaler restarts whenever counting is disabled. The first tick after enabling therefore comes one full divide period after the enabling write.
- R13: After reset, every register reads 0, and irq and tmr_out are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | 2 | Word address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 1 | Interrupt request |
| tmr_out | output | 1 | Timer output pin, held Low |

## Verification
A counter match event and a software write of 0 to the match flag can land on the same clock edge. If the clear were given priority, one interrupt would be lost. The bench runs the channel in wrap-on-match mode with a known divide ratio and a known compare value, so the match edges fall at fixed offsets from the enabling write. It then issues a flag clear timed to hit one of those edges exactly, and expects the flag to read 1 afterwards. A second clear placed between two matches serves as the control case and is expected to leave the flag at 0.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   localparam int CODE_W = 3;
   localparam int MODE_W = 2;
   localparam int ADDR_W = 2;

   localparam logic [ADDR_W-1:0] A_CTRL  = 2'd0;
   localparam logic [ADDR_W-1:0] A_CMP   = 2'd1;
   localparam logic [ADDR_W-1:0] A_COUNT = 2'd2;
   localparam logic [ADDR_W-1:0] A_STAT  = 2'd3;

   localparam int B_EN   = 0;
   localparam int B_CLR  = 1;
   localparam int B_WRAP = 2;
   localparam int B_IE   = 3;
   localparam int B_MODE = 4;
   localparam int B_CODE = 8;

   localparam logic [MODE_W-1:0] MODE_INTERVAL = 2'b00;

   typedef struct packed {
      logic [CODE_W-1:0] code;
      logic [MODE_W-1:0] mode;
      logic              ie;
      logic              wrap;
      logic              clr_stop;
      logic              en;
   } ctrl_t;

endpackage

// File: rtl/tmr_presc.sv
module tmr_presc
   import tmr_pkg::*;
#(
   parameter int CW = CODE_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic [CW-1:0] code,
   output logic          tick
);
   localparam int PW = 2 ** CW;

   logic [PW-1:0] pcnt;
   logic [PW:0]   lim;
   logic [CW:0]   shamt;

   always_comb begin
      shamt = {1'b0, code} + 1'b1;
      lim   = ({{PW{1'b0}}, 1'b1} << shamt) - 1'b1;
      tick  = run && (pcnt == lim[PW-1:0]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pcnt <= '0;
      else if (!run)   pcnt <= '0;
      else if (tick)   pcnt <= '0;
      else             pcnt <= pcnt + 1'b1;
   end
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             clr_stop,
   input  logic             wrap,
   input  logic             tick,
   input  logic [CNT_W-1:0] cmp,
   output logic [CNT_W-1:0] count,
   output logic             set_evt
);
   logic             at_cmp;
   logic [CNT_W-1:0] nxt;

   always_comb begin
      at_cmp  = (count == cmp);
      nxt     = count;
      set_evt = 1'b0;
      if (tick) begin
         if (at_cmp) begin
            if (wrap) nxt = '0;
         end else begin
            nxt = count + 1'b1;
         end
         set_evt = !(at_cmp && !wrap) && (nxt == cmp);
      end
      if (!run && clr_stop) nxt = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) count <= '0;
      else        count <= nxt;
   end
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
   import tmr_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [CNT_W-1:0]  count,
   input  logic              set_evt,
   output ctrl_t             ctrl,
   output logic [CNT_W-1:0]  cmp,
   output logic              flag,
   output logic              clr_wr
);
   localparam int CTRL_W = $bits(ctrl_t);

   logic wr_ctrl, wr_cmp;
   logic unused_wbits;

   assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
   assign wr_cmp  = bus_wr && (bus_addr == A_CMP);
   assign clr_wr  = bus_wr && (bus_addr == A_STAT) && !bus_wdata[0];
   assign unused_wbits = ^{bus_wdata[7:6], bus_wdata[DATA_W-1:B_CODE+CODE_W]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl <= '0;
         cmp  <= '0;
         flag <= 1'b0;
      end else begin
         if (wr_ctrl) begin
            ctrl.en       <= bus_wdata[B_EN];
            ctrl.clr_stop <= bus_wdata[B_CLR];
            ctrl.wrap     <= bus_wdata[B_WRAP];
            ctrl.ie       <= bus_wdata[B_IE];
            ctrl.mode     <= bus_wdata[B_MODE +: MODE_W];
            ctrl.code     <= bus_wdata[B_CODE +: CODE_W];
         end
         if (wr_cmp) cmp <= bus_wdata[CNT_W-1:0];
         flag <= set_evt | (flag & ~clr_wr);
      end
   end

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         A_CTRL: begin
            bus_rdata[B_EN]                = ctrl.en;
            bus_rdata[B_CLR]               = ctrl.clr_stop;
            bus_rdata[B_WRAP]              = ctrl.wrap;
            bus_rdata[B_IE]                = ctrl.ie;
            bus_rdata[B_MODE +: MODE_W]    = ctrl.mode;
            bus_rdata[B_CODE +: CODE_W]    = ctrl.code;
         end
         A_CMP:   bus_rdata[CNT_W-1:0] = cmp;
         A_COUNT: bus_rdata[CNT_W-1:0] = count;
         A_STAT:  bus_rdata[0]         = flag;
         default: bus_rdata = '0;
      endcase
   end

   if (CTRL_W > DATA_W) begin : g_bad_ctrl
      $error("control word wider than bus");
   end
endmodule

// File: rtl/interval_timer_chan.sv
module interval_timer_chan
   import tmr_pkg::*;
#(
   parameter int CNT_W   = 32,
   parameter int DATA_W  = 32,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq,
   output logic              tmr_out
);
   if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt
      $error("CNT_W must lie between 2 and DATA_W");
   end
   if (DATA_W < B_CODE + CODE_W) begin : g_bad_data
      $error("DATA_W too narrow for control fields");
   end

   ctrl_t            ctrl;
   logic [CNT_W-1:0] cmp;
   logic [CNT_W-1:0] count;
   logic             flag, clr_wr, set_evt, tick, run;

   assign run = ctrl.en && (ctrl.mode == MODE_INTERVAL);

   tmr_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .count(count),
      .set_evt(set_evt), .ctrl(ctrl), .cmp(cmp), .flag(flag), .clr_wr(clr_wr)
   );

   tmr_presc #(.CW(CODE_W)) u_presc (
      .clk(clk), .rst_n(rst_n), .run(run), .code(ctrl.code), .tick(tick)
   );

   tmr_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .run(run), .clr_stop(ctrl.clr_stop),
      .wrap(ctrl.wrap), .tick(tick), .cmp(cmp), .count(count), .set_evt(set_evt)
   );

   if (IRQ_REG) begin : g_irq_ff
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= flag && ctrl.ie;
      end
      assign irq = irq_q;
   end else begin : g_irq_comb
      assign irq = flag && ctrl.ie;
   end

   assign tmr_out = 1'b0;
endmodule

// File: rtl/interval_timer_chan_chk.sv
module interval_timer_chan_chk #(
   parameter int CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run,
   input logic             tick,
   input logic             clr_stop,
   input logic             wrap,
   input logic [CNT_W-1:0] count,
   input logic [CNT_W-1:0] cmp,
   input logic             flag,
   input logic             clr_wr,
   input logic             set_evt,
   input logic             irq
);
   assert_tick_needs_run_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> !tick);

   assert_hold_between_ticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !tick) |=> $stable(count));

   assert_zero_on_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && clr_stop) |=> (count == '0));

   assert_keep_on_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !clr_stop) |=> $stable(count));

   assert_flag_on_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && count != cmp && (count + 1'b1) == cmp) |=> flag);

   assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !clr_wr) |=> flag);

   assert_set_beats_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (set_evt && clr_wr) |=> flag);

   assert_wrap_to_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && count == cmp && wrap) |=> (count == '0));

   assert_stop_at_cmp_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && count == cmp && !wrap) |=> $stable(count));

   assert_irq_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag && !$past(flag)) |-> !irq);
endmodule

bind interval_timer_chan interval_timer_chan_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .clr_stop(ctrl.clr_stop),
   .wrap(ctrl.wrap), .count(count), .cmp(cmp), .flag(flag), .clr_wr(clr_wr),
   .set_evt(set_evt), .irq(irq)
);

// File: tb/interval_timer_chan_test.sv
module interval_timer_chan_test;
   localparam time PERIOD = 10ns;
   localparam int  NV = 7;
   localparam int V_CODE[NV] = '{0, 1, 2, 3, 3, 7, 0};
   localparam int V_CMP [NV] = '{1000, 1000, 1000, 1000, 1000, 1000, 4};
   localparam int V_WAIT[NV] = '{20, 22, 33, 15, 16, 600, 30};
   localparam int V_EXP [NV] = '{10, 5, 4, 0, 1, 2, 4};
   localparam string V_REQ[NV] = '{"R1", "R1", "R1", "R12", "R12", "R1", "R8"};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq, tmr_out;

   int n_chk = 0;
   int n_fail = 0;

   interval_timer_chan uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .tmr_out(tmr_out)
   );

   always #(PERIOD/2) clk = ~clk;

   function automatic logic [31:0] mk(input bit en, input bit clr, input bit wrap,
                                      input bit ie, input int mode, input int code);
      logic [31:0] v = '0;
      v[0] = en; v[1] = clr; v[2] = wrap; v[3] = ie;
      v[5:4] = mode[1:0]; v[10:8] = code[2:0];
      return v;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic summary;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      #(PERIOD * 100000);
      n_fail++;
      $display("FAIL watchdog R13 actual=timeout expected=done");
      summary();
      $finish;
   end

   initial begin
      logic [31:0] d;
      // R13: reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      rd(2'd0, d); chk("R13 ctrl", d, 0);
      rd(2'd1, d); chk("R13 cmp", d, 0);
      rd(2'd2, d); chk("R13 count", d, 0);
      rd(2'd3, d); chk("R13 stat", d, 0);
      chk("R13 irq", irq, 0);
      chk("R9 tmr_out", tmr_out, 0);
      rst_n = 1'b1;

      // R10: readback
      wr(2'd1, 32'h1234_5678);
      rd(2'd1, d); chk("R10 cmp", d, 32'h1234_5678);
      wr(2'd0, mk(0, 1, 1, 1, 2, 5));
      rd(2'd0, d); chk("R10 ctrl", d, mk(0, 1, 1, 1, 2, 5));

      // R1/R12/R8: vector table
      for (int i = 0; i < NV; i++) begin
         wr(2'd0, mk(0, 1, 0, 0, 0, 0));
         wr(2'd3, 32'd0);
         wr(2'd1, V_CMP[i]);
         wr(2'd0, mk(1, 0, 0, 0, 0, V_CODE[i]));
         repeat (V_WAIT[i]) @(posedge clk);
         @(negedge clk);
         rd(2'd2, d); chk(V_REQ[i], d, V_EXP[i]);
         chk("R9 tmr_out", tmr_out, 0);
      end

      // R4/R5/R8: match, flag, irq, stop
      wr(2'd0, mk(0, 1, 0, 0, 0, 0));
      wr(2'd3, 32'd0);
      wr(2'd1, 32'd5);
      wr(2'd0, mk(1, 0, 0, 1, 0, 0));
      repeat (9) @(posedge clk);
      @(negedge clk);
      rd(2'd3, d); chk("R4 flag before", d, 0);
      chk("R5 irq before", irq, 0);
      @(posedge clk); @(negedge clk);
      rd(2'd3, d); chk("R4 flag at match", d, 1);
      rd(2'd2, d); chk("R4 count at match", d, 5);
      chk("R5 irq at match", irq, 1);
      repeat (20) @(posedge clk); @(negedge clk);
      rd(2'd2, d); chk("R8 stopped", d, 5);
      wr(2'd3, 32'd0);
      rd(2'd3, d); chk("R6 cleared", d, 0);
      chk("R5 irq after clear", irq, 0);
      wr(2'd3, 32'd1);
      repeat (10) @(posedge clk); @(negedge clk);
      rd(2'd3, d); chk("R6 write1 no set", d, 0);
      chk("R8 no new event irq", irq, 0);

      // R3: disable with and without clear-on-stop
      wr(2'd0, mk(0, 0, 0, 1, 0, 0));
      repeat (5) @(posedge clk); @(negedge clk);
      rd(2'd2, d); chk("R3 hold", d, 5);
      wr(2'd0, mk(0, 1, 0, 1, 0, 0));
      @(posedge clk); @(negedge clk);
      rd(2'd2, d); chk("R3 zero", d, 0);

      // R2: non-interval mode does not count
      wr(2'd0, mk(1, 0, 0, 0, 1, 0));
      repeat (20) @(posedge clk); @(negedge clk);
      rd(2'd2, d); chk("R2 mode01 stopped", d, 0);

      // R7/R5: wrap on match, irq gated off
      wr(2'd0, mk(0, 1, 0, 0, 0, 0));
      wr(2'd1, 32'd3);
      wr(2'd0, mk(1, 0, 1, 0, 0, 0));
      repeat (7) @(posedge clk); @(negedge clk);
      rd(2'd2, d); chk("R7 at cmp", d, 3);
      rd(2'd3, d); chk("R4 flag wrap", d, 1);
      chk("R5 irq disabled", irq, 0);
      @(posedge clk); @(negedge clk);
      rd(2'd2, d); chk("R7 wrapped", d, 0);
      wr(2'd3, 32'd1);
      rd(2'd3, d); chk("R6 write1 keeps", d, 1);
      rd(2'd2, d); chk("R7 continues", d, 1);

      // R11: set versus clear on the same edge
      wr(2'd0, mk(0, 1, 0, 0, 0, 0));
      wr(2'd3, 32'd0);
      wr(2'd0, mk(1, 0, 1, 0, 0, 0));
      repeat (9) @(posedge clk);
      wr(2'd3, 32'd0);
      rd(2'd3, d); chk("R11 control clear", d, 0);
      repeat (3) @(posedge clk);
      wr(2'd3, 32'd0);
      rd(2'd3, d); chk("R11 set wins", d, 1);
      rd(2'd2, d); chk("R11 count", d, 3);
      chk("R9 tmr_out end", tmr_out, 0);

      summary();
      $finish;
   end
endmodule